// File: doc/BRIEF.md
# Base-Register Mapped Local SRAM

This block is a small on-chip word memory whose location in the processor address map, and whose access rights, are set by a single 32-bit base register. Software loads that register through a one-cycle configuration write port and can read it back at any time. Each processor access presents an address, a read/write flag, an instruction-fetch/data flag and a 3-bit address-space code. The block decides from the register whether the access belongs to the memory.

A qualifying read returns the stored word. A qualifying write updates the array unless write protection is on. In that case the write is dropped and an access error is raised instead. Any access that does not qualify produces a "not mapped" strobe, so that surrounding logic can send it on as an ordinary reference.

The response path is a small state machine. On every clock edge it records the outcome of the access in progress, and the outputs are decoded from that state for exactly one cycle:
- `ST_IDLE`: no request.
- `ST_RD`: read hit.
- `ST_WR`: write hit.
- `ST_PROT`: protected write.
- `ST_MISS`: not mapped.

From any state the machine moves as follows:
- No request leads to `ST_IDLE`.
- A request that fails the hit decision leads to `ST_MISS`.
- A hitting read leads to `ST_RD`.
- A hitting write with protection off leads to `ST_WR`.
- A hitting write with protection on leads to `ST_PROT`.

Top module: `lsram_top`

## Requirements
- R1: Reset clears the whole base register, so it reads back 0 and the block is disabled; all response outputs are 0 after reset. Reset leaves the memory contents as they are.
- R2: While register bit 0 (enable) is 0, no access hits; every request gives `rsp_unmapped`=1, `rsp_hit`=0.
- R3: Register bit 7 selects the side. When it is 1, only requests with `acc_ifetch`=1 can hit. When it is 0, only requests with `acc_ifetch`=0 can hit.
- R4: A request can hit only when `acc_addr[31:N]` equals register bits 31:N, where N = log2(SIZE_BYTES) (default 12). The word index is `acc_addr[N-1:2]`.
- R5: Register bits 5..1 inhibit address-space codes 0..4 respectively: bit 5 for code 0 (CPU space), bit 4 for code 1 (supervisor code), bit 3 for code 2 (supervisor data), bit 2 for code 3 (user code) and bit 1 for code 4 (user data). A set bit makes a request with that code miss. Codes 5 to 7 never hit.
- R6: A read hit gives `rsp_hit`=1 and the stored word on `rsp_rdata`. Both appear in the cycle after the request and last one cycle.
- R7: A write hit with register bit 8 = 0 stores `acc_wdata` into the addressed word and gives `rsp_hit`=1, `rsp_perr`=0.
- R8: A write hit with register bit 8 = 1 leaves the word unchanged and gives `rsp_hit`=1, `rsp_perr`=1.
- R9: Register bit 6 and bits N-1..9 always read back 0, and writing them has no effect on hit decisions.
- R10: A register write in the same cycle as a request does not affect that request; it applies from the next request.
- R11: In the cycle after a cycle without a request, `rsp_hit`, `rsp_perr` and `rsp_unmapped` are 0. `rsp_rdata` is 0 in every cycle that is not a read-hit response.
- R12: `rsp_hit` and `rsp_unmapped` are never 1 together, and `rsp_perr` implies `rsp_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_wdata | input | 32 | Base register write value |
| cfg_rdata | output | 32 | Base register read-back |
| acc_req | input | 1 | Access request valid |
| acc_addr | input | 32 | Access byte address |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ifetch | input | 1 | 1 = instruction fetch, 0 = data reference |
| acc_space | input | 3 | Address-space code (0..4) |
| acc_wdata | input | 32 | Write data |
| rsp_hit | output | 1 | Access was mapped to the memory |
| rsp_rdata | output | 32 | Read data of a read hit |
| rsp_perr | output | 1 | Write-protect access error |
| rsp_unmapped | output | 1 | Access must be handled outside the memory |

## Verification
Each qualifying factor is tried on its own, with every other factor held in the hitting setting. The varied factors are:
- the enable bit;
- each side selection against each kind of request;
- addresses at the first, last and one-past-last word;
- a far base;
- each inhibit bit against its own code and a neighbouring code;
- an undefined code.

This shows whether a miss comes from the intended field and not from a wrong bit position or a swapped mask order. Writes with protection on are followed by a read of the same word, which separates a dropped write from a stored one. Register writes that coincide with a request show whether the decision uses the old or the new register value.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

    // response states, one per access outcome
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_PROT = 3'd3,
        ST_MISS = 3'd4
    } rsp_state_e;

    // bit positions inside the base register
    localparam int unsigned POS_EN      = 0;
    localparam int unsigned POS_MASK_HI = 5;
    localparam int unsigned POS_RSVD    = 6;
    localparam int unsigned POS_SIDE    = 7;
    localparam int unsigned POS_WPROT   = 8;
    localparam int unsigned POS_LOWBASE = 9;

    // number of defined address-space codes
    localparam int unsigned NUM_SPACES  = 5;

endpackage

// File: rtl/lsram_basereg.sv
module lsram_basereg #(
    parameter int unsigned AW = 32,
    parameter int unsigned LG = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_val,
    output logic [AW-1:0] bar_q
);
    import lsram_pkg::*;

    localparam int unsigned HOLE_W = LG - POS_LOWBASE;
    // writable: base bits, protect, side, inhibit masks, enable
    localparam logic [AW-1:0] KEEP_MASK =
        {{(AW-LG){1'b1}}, {HOLE_W{1'b0}}, 9'b1_1011_1111};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bar_q <= '0;
        end else if (wr_en) begin
            bar_q <= wr_val & KEEP_MASK;
        end
    end

    // R9: unimplemented bits never hold a 1
    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_q & ~KEEP_MASK) == '0);

endmodule

// File: rtl/lsram_hitdec.sv
module lsram_hitdec #(
    parameter int unsigned AW = 32,
    parameter int unsigned LG = 12
) (
    input  logic [AW-1:0] bar,
    input  logic [AW-1:0] addr,
    input  logic          ifetch,
    input  logic [2:0]    space,
    output logic          hit,
    output logic          wprot
);
    import lsram_pkg::*;

    logic en_ok;
    logic side_ok;
    logic base_ok;
    logic space_blk;
    logic unused_lowaddr;

    assign en_ok   = bar[POS_EN];
    assign side_ok = (ifetch == bar[POS_SIDE]);
    assign base_ok = (addr[AW-1:LG] == bar[AW-1:LG]);
    assign wprot   = bar[POS_WPROT];
    assign unused_lowaddr = ^{addr[LG-1:0], bar[LG-1:POS_WPROT+1], bar[POS_RSVD]};

    // code c is inhibited by mask bit (POS_MASK_HI - c); undefined codes are blocked
    always_comb begin
        space_blk = 1'b1;
        for (int c = 0; c < NUM_SPACES; c++) begin
            if (space == 3'(c)) begin
                space_blk = bar[POS_MASK_HI - c];
            end
        end
    end

    assign hit = en_ok && side_ok && base_ok && !space_blk;

endmodule

// File: rtl/lsram_array.sv
module lsram_array #(
    parameter int unsigned DW    = 32,
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wd,
    output logic [DW-1:0]    rd
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DW-1:0] store [DEPTH];

    // contents are deliberately left without reset
    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= wd;
        end
        if (re) begin
            rd <= store[idx];
        end
    end

endmodule

// File: rtl/lsram_top.sv
module lsram_top #(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned SIZE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          acc_req,
    input  logic [31:0]   acc_addr,
    input  logic          acc_wr,
    input  logic          acc_ifetch,
    input  logic [2:0]    acc_space,
    input  logic [31:0]   acc_wdata,
    output logic          rsp_hit,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_perr,
    output logic          rsp_unmapped
);
    import lsram_pkg::*;

    localparam int unsigned LG     = $clog2(SIZE_BYTES);
    localparam int unsigned BYTES  = DW / 8;
    localparam int unsigned LG_B   = $clog2(BYTES);
    localparam int unsigned IDX_W  = LG - LG_B;

    logic [AW-1:0]    bar_q;
    logic             dec_hit;
    logic             dec_wprot;
    logic             mem_we;
    logic             mem_re;
    logic [DW-1:0]    mem_rd;
    logic [IDX_W-1:0] word_idx;
    logic             unused_byte_bits;
    rsp_state_e       state_q;
    rsp_state_e       state_d;

    assign word_idx         = acc_addr[LG-1:LG_B];
    assign unused_byte_bits = ^acc_addr[LG_B-1:0];

    lsram_basereg #(.AW(AW), .LG(LG)) u_bar (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_val (cfg_wdata),
        .bar_q  (bar_q)
    );

    lsram_hitdec #(.AW(AW), .LG(LG)) u_dec (
        .bar    (bar_q),
        .addr   (acc_addr),
        .ifetch (acc_ifetch),
        .space  (acc_space),
        .hit    (dec_hit),
        .wprot  (dec_wprot)
    );

    assign mem_we = acc_req && dec_hit && acc_wr && !dec_wprot;
    assign mem_re = acc_req && dec_hit && !acc_wr;

    lsram_array #(.DW(DW), .IDX_W(IDX_W)) u_mem (
        .clk (clk),
        .we  (mem_we),
        .re  (mem_re),
        .idx (word_idx),
        .wd  (acc_wdata),
        .rd  (mem_rd)
    );

    // next-state: outcome of the request in this cycle
    always_comb begin
        if (!acc_req) begin
            state_d = ST_IDLE;
        end else if (!dec_hit) begin
            state_d = ST_MISS;
        end else if (!acc_wr) begin
            state_d = ST_RD;
        end else if (dec_wprot) begin
            state_d = ST_PROT;
        end else begin
            state_d = ST_WR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the response state
    always_comb begin
        rsp_hit      = 1'b0;
        rsp_perr     = 1'b0;
        rsp_unmapped = 1'b0;
        rsp_rdata    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD: begin
                rsp_hit   = 1'b1;
                rsp_rdata = mem_rd;
            end
            ST_WR:   rsp_hit = 1'b1;
            ST_PROT: begin
                rsp_hit  = 1'b1;
                rsp_perr = 1'b1;
            end
            ST_MISS: rsp_unmapped = 1'b1;
            default: ;
        endcase
    end

    assign cfg_rdata = bar_q;

    assert_off_nohit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !bar_q[POS_EN]) |=> (rsp_unmapped && !rsp_hit));

    assert_side_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && (acc_ifetch != bar_q[POS_SIDE])) |=> rsp_unmapped);

    assert_wprot_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wr && dec_hit && bar_q[POS_WPROT]) |=> (rsp_perr && rsp_hit));

    assert_wprot_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && bar_q[POS_WPROT]) |-> !mem_we);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> (!rsp_hit && !rsp_unmapped && !rsp_perr));

    assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_unmapped) && (!rsp_perr || rsp_hit));

    assert_state_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_unmapped}));

endmodule

// File: tb/tb_lsram_top.sv
module tb_lsram_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_req = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        acc_ifetch = 1'b0;
    logic [2:0]  acc_space = '0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_hit;
    logic [31:0] rsp_rdata;
    logic        rsp_perr;
    logic        rsp_unmapped;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    lsram_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_req(acc_req), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_ifetch(acc_ifetch), .acc_space(acc_space), .acc_wdata(acc_wdata),
        .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .rsp_unmapped(rsp_unmapped)
    );

    typedef struct packed {
        logic [31:0] bar;
        logic [31:0] addr;
        logic        wr;
        logic        ifetch;
        logic [2:0]  space;
        logic [31:0] wdata;
        logic        e_hit;
        logic        e_unm;
        logic        e_perr;
        logic [31:0] e_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam logic [31:0] B  = 32'h2000_0000;
    localparam logic [31:0] D1 = 32'hA5A5_0001;
    localparam logic [31:0] D3 = 32'hC3C3_0FFC;

    localparam vec_t VT [NV] = '{
        '{B|32'h1,   B|32'h10,   1'b1, 1'b0, 3'd4, D1,           1'b1, 1'b0, 1'b0, 32'h0, 4'd7},  // R7
        '{B|32'h1,   B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd6},  // R6
        '{B|32'h1,   B|32'hFFC,  1'b1, 1'b0, 3'd3, D3,           1'b1, 1'b0, 1'b0, 32'h0, 4'd4},  // R4 last word
        '{B|32'h1,   B|32'hFFC,  1'b0, 1'b0, 3'd3, 32'h0,        1'b1, 1'b0, 1'b0, D3,    4'd4},  // R4
        '{B|32'h1,   B|32'h10,   1'b0, 1'b1, 3'd1, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd3},  // R3 fetch on data side
        '{B|32'h81,  B|32'h10,   1'b0, 1'b1, 3'd1, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd3},  // R3
        '{B|32'h81,  B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd3},  // R3 data on fetch side
        '{B,         B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd2},  // R2
        '{B|32'h1,   B|32'h1010, 1'b0, 1'b0, 3'd4, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd4},  // R4 one past
        '{B|32'h1,   32'h3000_0010, 1'b0, 1'b0, 3'd4, 32'h0,     1'b0, 1'b1, 1'b0, 32'h0, 4'd4},  // R4 far
        '{B|32'h3,   B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd5},  // R5 code4/bit1
        '{B|32'h3,   B|32'h10,   1'b0, 1'b0, 3'd2, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd5},  // R5
        '{B|32'h9,   B|32'h10,   1'b0, 1'b0, 3'd2, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd5},  // R5 code2/bit3
        '{B|32'h21,  B|32'h10,   1'b0, 1'b0, 3'd0, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd5},  // R5 code0/bit5
        '{B|32'h21,  B|32'h10,   1'b0, 1'b0, 3'd3, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd5},  // R5
        '{B|32'h5,   B|32'h10,   1'b0, 1'b0, 3'd3, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd5},  // R5 code3/bit2
        '{B|32'h1,   B|32'h10,   1'b0, 1'b0, 3'd5, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0, 4'd5},  // R5 undefined
        '{B|32'h101, B|32'h10,   1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF,1'b1, 1'b0, 1'b1, 32'h0, 4'd8},  // R8
        '{B|32'h1,   B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd8},  // R8 unchanged
        '{B|32'hE01, B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd9},  // R9 bits 11:9
        '{B|32'h41,  B|32'h10,   1'b0, 1'b0, 3'd4, 32'h0,        1'b1, 1'b0, 1'b0, D1,    4'd9}   // R9 bit 6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // request driven for one cycle; response sampled at the following negedge
    task automatic access(input logic [31:0] a, input logic w, input logic f,
                          input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_req = 1'b1; acc_addr = a; acc_wr = w; acc_ifetch = f;
        acc_space = s; acc_wdata = d;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bar", cfg_rdata, 32'h0);
        chk("R1 out", {29'h0, rsp_hit, rsp_perr, rsp_unmapped}, 32'h0);
        rst_n = 1'b1;
        access(B | 32'h10, 1'b0, 1'b0, 3'd4, 32'h0);
        chk("R1 disabled", {30'h0, rsp_hit, rsp_unmapped}, 32'h1);

        // R9: unimplemented bits read as zero
        cfg_write(32'hFFFF_FFFF);
        chk("R9 readback", cfg_rdata, 32'hFFFF_F1BF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            cfg_write(VT[i].bar);
            access(VT[i].addr, VT[i].wr, VT[i].ifetch, VT[i].space, VT[i].wdata);
            chk($sformatf("R%0d hit v%0d", VT[i].req, i), {31'h0, rsp_hit}, {31'h0, VT[i].e_hit});
            chk($sformatf("R%0d unm v%0d", VT[i].req, i), {31'h0, rsp_unmapped}, {31'h0, VT[i].e_unm});
            chk($sformatf("R%0d perr v%0d", VT[i].req, i), {31'h0, rsp_perr}, {31'h0, VT[i].e_perr});
            chk($sformatf("R%0d rdata v%0d", VT[i].req, i), rsp_rdata, VT[i].e_rd);
            chk("R12 excl", {31'h0, rsp_hit & rsp_unmapped}, 32'h0);
        end

        // R11: idle cycle after activity gives quiet outputs
        @(negedge clk);
        chk("R11 idle", {rsp_rdata[28:0], rsp_hit, rsp_perr, rsp_unmapped}, 32'h0);

        // R10: register write coinciding with a request
        cfg_write(B | 32'h1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h0;
        acc_req = 1'b1; acc_addr = B | 32'h10; acc_wr = 1'b0;
        acc_ifetch = 1'b0; acc_space = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0; acc_req = 1'b0;
        chk("R10 old value hit", {31'h0, rsp_hit}, 32'h1);
        chk("R10 old value data", rsp_rdata, D1);
        access(B | 32'h10, 1'b0, 1'b0, 3'd4, 32'h0);
        chk("R10 new value miss", {30'h0, rsp_hit, rsp_unmapped}, 32'h1);

        // R11: rdata zero on a write-hit response
        cfg_write(B | 32'h1);
        access(B | 32'h20, 1'b1, 1'b0, 3'd4, 32'h1234_5678);
        chk("R11 wr rdata", rsp_rdata, 32'h0);
        // R7: the new word reads back
        access(B | 32'h20, 1'b0, 1'b0, 3'd4, 32'h0);
        chk("R7 readback", rsp_rdata, 32'h1234_5678);
        // R6: single-cycle response
        @(negedge clk);
        chk("R6 one cycle", {31'h0, rsp_hit}, 32'h0);

        finish_run();
    end

endmodule